// File: doc/BRIEF.md
# Bank-Switchable Two-Port Word Memory

This block is a two-port memory split into four independent banks of 16-bit words. Each bank belongs to exactly one of the two ports at any time. A dedicated select input per bank decides its owner, and flipping that input hands the bank, with its contents intact, to the other side. Each port carries its own chip enables, read/write and output-enable controls, byte-lane enables, a bank field that names one of the four banks, and a word address inside that bank. Storage is synchronous register storage.

A port that names a bank it does not own is refused. Its write is dropped, its read returns zero, and a refusal flag rises with the read data. Ownership is exclusive, so the two ports never meet inside one bank and no arbitration exists. Typical use is a pair of processors that swap whole buffers by toggling bank selects rather than copying data.

The word address width is a parameter. The full-size part uses 13 bits (8K words per bank). The default configuration uses 8 bits to keep elaboration small.

Top module: `bsdp_mem`

## Requirements
- R1: After reset, both read data outputs are zero and both refusal flags are low until an access is made.
- R2: A bank whose select bit is 0 is owned by the left port, and a bank whose select bit is 1 is owned by the right port. A selected owner can write to the bank and read it back.
- R3: A selected access to a bank the port does not own leaves that bank unchanged. On the next cycle it returns zero read data with the refusal flag high.
- R4: A port is selected only when both of its chip enables are 1. An unselected port writes nothing, returns zero read data and keeps its refusal flag low.
- R5: Read data appears on the clock after the address, and only when the port is selected, owns the bank, read/write is 1 (read) and output enable is 1. In every other case the read data is zero.
- R6: On a write (read/write = 0), lane bit 0 enables data bits 7:0 and lane bit 1 enables bits 15:8. Bytes whose lane bit is 0 keep their old value.
- R7: On a read, bytes whose lane bit is 0 are returned as zero.
- R8: The two ports, each accessing a bank it owns, complete their accesses in the same cycle independently.
- R9: The 2-bit bank field picks the bank, and the word address picks a word within it. The same word address in different banks names distinct storage.
- R10: A change of a bank select bit takes effect for accesses in that same cycle, and the bank keeps its contents across the handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| bank_sel | input | NUM_BANKS | Per-bank owner select, 0 = left, 1 = right |
| l_ce0 | input | 1 | Left chip enable 0 |
| l_ce1 | input | 1 | Left chip enable 1 |
| l_rw | input | 1 | Left read (1) or write (0) |
| l_oe | input | 1 | Left output enable |
| l_lanes | input | DATA_W/8 | Left byte-lane enables |
| l_bank | input | 2 | Left bank field |
| l_addr | input | WORD_AW | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_noacc | output | 1 | Left refusal flag |
| r_ce0 | input | 1 | Right chip enable 0 |
| r_ce1 | input | 1 | Right chip enable 1 |
| r_rw | input | 1 | Right read (1) or write (0) |
| r_oe | input | 1 | Right output enable |
| r_lanes | input | DATA_W/8 | Right byte-lane enables |
| r_bank | input | 2 | Right bank field |
| r_addr | input | WORD_AW | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_noacc | output | 1 | Right refusal flag |

## Verification
Two things can land in one cycle. One is an owned access by one port. The other is either an owned access by the other port to a different bank, or a refused access by the other port to that same bank. The random phase provokes both by drawing fresh bank selects every cycle while both ports issue accesses over a narrow address window. Directed cases add a handover in the very cycle of the access. Each port's result is judged against a bench model that applies ownership, chip-enable, lane and output-enable rules to its own copy of the storage.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
    typedef enum logic {
        OWN_LEFT  = 1'b0,
        OWN_RIGHT = 1'b1
    } owner_e;

    localparam int NUM_PORTS = 2;
    localparam int LANE_W    = 8;
endpackage

// File: rtl/bsdp_port_decode.sv
module bsdp_port_decode
    import bsdp_pkg::*;
#(
    parameter int     NUM_BANKS = 4,
    parameter int     LANES     = 2,
    parameter owner_e SIDE      = OWN_LEFT
) (
    input  logic                         ce0,
    input  logic                         ce1,
    input  logic                         rw,
    input  logic                         oe,
    input  logic [LANES-1:0]             lanes,
    input  logic [$clog2(NUM_BANKS)-1:0] bank,
    input  logic [NUM_BANKS-1:0]         bank_sel,
    output logic [LANES-1:0]             wr_lanes,
    output logic                         rd_en,
    output logic                         miss
);
    logic selected;
    logic owned;

    always_comb begin
        selected = ce0 & ce1;
        owned    = (bank_sel[bank] == logic'(SIDE));
        miss     = selected & ~owned;
        wr_lanes = (selected & owned & ~rw) ? lanes : '0;
        rd_en    = selected & owned & rw & oe;
    end
endmodule

// File: rtl/bsdp_bank.sv
module bsdp_bank
    import bsdp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int WORD_AW = 8,
    parameter int BANK_AW = 2,
    parameter int IDX     = 0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0][DATA_W/8-1:0]    wr_lanes,
    input  logic [NUM_PORTS-1:0]                  rd_en,
    input  logic [NUM_PORTS-1:0][BANK_AW-1:0]     bank,
    input  logic [NUM_PORTS-1:0][WORD_AW-1:0]     addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]                     rdata
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int DEPTH = 1 << WORD_AW;

    typedef struct packed {
        logic [LANES-1:0]   wr;
        logic               rd;
        logic [WORD_AW-1:0] addr;
        logic [DATA_W-1:0]  wdata;
    } req_t;

    req_t              req;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    // Ownership is exclusive, so at most one port matches this bank.
    always_comb begin
        req = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bank[p] == BANK_AW'(IDX) && (wr_lanes[p] != '0 || rd_en[p])) begin
                req.wr    = wr_lanes[p];
                req.rd    = rd_en[p];
                req.addr  = addr[p];
                req.wdata = wdata[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++) begin
            if (req.wr[g]) begin
                mem_q[req.addr][g*LANE_W +: LANE_W] <= req.wdata[g*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        rd_d = req.rd ? mem_q[req.addr] : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/bsdp_port_out.sv
module bsdp_port_out
    import bsdp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_en,
    input  logic                                miss,
    input  logic [$clog2(NUM_BANKS)-1:0]        bank,
    input  logic [DATA_W/8-1:0]                 lanes,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_rdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic                                noacc
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int BANK_AW = $clog2(NUM_BANKS);

    typedef struct packed {
        logic               vld;
        logic               noacc;
        logic [BANK_AW-1:0] bank;
        logic [LANES-1:0]   lanes;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = rd_en;
        st_d.noacc = miss;
        if (rd_en) begin
            st_d.bank  = bank;
            st_d.lanes = lanes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (st_q.vld) begin
            for (int g = 0; g < LANES; g++) begin
                if (st_q.lanes[g]) begin
                    rdata[g*LANE_W +: LANE_W] = bank_rdata[st_q.bank][g*LANE_W +: LANE_W];
                end
            end
        end
        noacc = st_q.noacc;
    end
endmodule

// File: rtl/bsdp_mem.sv
module bsdp_mem
    import bsdp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int WORD_AW   = 8,
    parameter int NUM_BANKS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANKS-1:0]         bank_sel,
    input  logic                         l_ce0,
    input  logic                         l_ce1,
    input  logic                         l_rw,
    input  logic                         l_oe,
    input  logic [DATA_W/8-1:0]          l_lanes,
    input  logic [$clog2(NUM_BANKS)-1:0] l_bank,
    input  logic [WORD_AW-1:0]           l_addr,
    input  logic [DATA_W-1:0]            l_wdata,
    output logic [DATA_W-1:0]            l_rdata,
    output logic                         l_noacc,
    input  logic                         r_ce0,
    input  logic                         r_ce1,
    input  logic                         r_rw,
    input  logic                         r_oe,
    input  logic [DATA_W/8-1:0]          r_lanes,
    input  logic [$clog2(NUM_BANKS)-1:0] r_bank,
    input  logic [WORD_AW-1:0]           r_addr,
    input  logic [DATA_W-1:0]            r_wdata,
    output logic [DATA_W-1:0]            r_rdata,
    output logic                         r_noacc
);
    localparam int LANES   = DATA_W / LANE_W;
    localparam int BANK_AW = $clog2(NUM_BANKS);

    logic [NUM_PORTS-1:0]                  ce0_a, ce1_a, rw_a, oe_a;
    logic [NUM_PORTS-1:0][LANES-1:0]       lanes_a;
    logic [NUM_PORTS-1:0][BANK_AW-1:0]     bank_a;
    logic [NUM_PORTS-1:0][WORD_AW-1:0]     addr_a;
    logic [NUM_PORTS-1:0][DATA_W-1:0]      wdata_a;
    logic [NUM_PORTS-1:0][LANES-1:0]       wr_lanes_a;
    logic [NUM_PORTS-1:0]                  rd_en_a, miss_a, noacc_a;
    logic [NUM_PORTS-1:0][DATA_W-1:0]      rdata_a;
    logic [NUM_BANKS-1:0][DATA_W-1:0]      bank_rdata;

    assign ce0_a   = {r_ce0, l_ce0};
    assign ce1_a   = {r_ce1, l_ce1};
    assign rw_a    = {r_rw, l_rw};
    assign oe_a    = {r_oe, l_oe};
    assign lanes_a = {r_lanes, l_lanes};
    assign bank_a  = {r_bank, l_bank};
    assign addr_a  = {r_addr, l_addr};
    assign wdata_a = {r_wdata, l_wdata};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        bsdp_port_decode #(
            .NUM_BANKS (NUM_BANKS),
            .LANES     (LANES),
            .SIDE      (p == 0 ? OWN_LEFT : OWN_RIGHT)
        ) dec_i (
            .ce0      (ce0_a[p]),
            .ce1      (ce1_a[p]),
            .rw       (rw_a[p]),
            .oe       (oe_a[p]),
            .lanes    (lanes_a[p]),
            .bank     (bank_a[p]),
            .bank_sel (bank_sel),
            .wr_lanes (wr_lanes_a[p]),
            .rd_en    (rd_en_a[p]),
            .miss     (miss_a[p])
        );

        bsdp_port_out #(
            .DATA_W    (DATA_W),
            .NUM_BANKS (NUM_BANKS)
        ) out_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_en      (rd_en_a[p]),
            .miss       (miss_a[p]),
            .bank       (bank_a[p]),
            .lanes      (lanes_a[p]),
            .bank_rdata (bank_rdata),
            .rdata      (rdata_a[p]),
            .noacc      (noacc_a[p])
        );
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bsdp_bank #(
            .DATA_W  (DATA_W),
            .WORD_AW (WORD_AW),
            .BANK_AW (BANK_AW),
            .IDX     (b)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lanes (wr_lanes_a),
            .rd_en    (rd_en_a),
            .bank     (bank_a),
            .addr     (addr_a),
            .wdata    (wdata_a),
            .rdata    (bank_rdata[b])
        );
    end

    assign l_rdata = rdata_a[0];
    assign r_rdata = rdata_a[1];
    assign l_noacc = noacc_a[0];
    assign r_noacc = noacc_a[1];
endmodule

// File: rtl/bsdp_checker.sv
module bsdp_checker #(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_BANKS-1:0]         bank_sel,
    input logic                         l_ce0,
    input logic                         l_ce1,
    input logic                         l_rw,
    input logic                         l_oe,
    input logic [DATA_W/8-1:0]          l_lanes,
    input logic [$clog2(NUM_BANKS)-1:0] l_bank,
    input logic [DATA_W-1:0]            l_rdata,
    input logic                         l_noacc,
    input logic                         r_ce0,
    input logic                         r_ce1,
    input logic                         r_rw,
    input logic                         r_oe,
    input logic [DATA_W/8-1:0]          r_lanes,
    input logic [$clog2(NUM_BANKS)-1:0] r_bank,
    input logic [DATA_W-1:0]            r_rdata,
    input logic                         r_noacc
);
    function automatic logic [DATA_W-1:0] lane_mask(input logic [DATA_W/8-1:0] ln);
        logic [DATA_W-1:0] m;
        for (int g = 0; g < DATA_W/8; g++) m[g*8 +: 8] = {8{ln[g]}};
        return m;
    endfunction

    AST_L_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        l_noacc |-> l_rdata == '0); // R3
    AST_R_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_noacc |-> r_rdata == '0); // R3
    AST_L_REFUSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce0 && l_ce1 && bank_sel[l_bank]) |=> l_noacc); // R3
    AST_R_REFUSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce0 && r_ce1 && !bank_sel[r_bank]) |=> r_noacc); // R3
    AST_L_OWNED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce0 && l_ce1 && !bank_sel[l_bank]) |=> !l_noacc); // R2
    AST_R_OWNED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce0 && r_ce1 && bank_sel[r_bank]) |=> !r_noacc); // R2
    AST_L_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_ce0 && l_ce1) |=> (!l_noacc && l_rdata == '0)); // R4
    AST_R_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_ce0 && r_ce1) |=> (!r_noacc && r_rdata == '0)); // R4
    AST_L_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_oe || !l_rw) |=> l_rdata == '0); // R5
    AST_R_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_oe || !r_rw) |=> r_rdata == '0); // R5
    AST_L_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        l_rw |=> (l_rdata & ~lane_mask($past(l_lanes))) == '0); // R7
    AST_R_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        r_rw |=> (r_rdata & ~lane_mask($past(r_lanes))) == '0); // R7
endmodule

bind bsdp_mem bsdp_checker #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (bank_sel),
    .l_ce0    (l_ce0),
    .l_ce1    (l_ce1),
    .l_rw     (l_rw),
    .l_oe     (l_oe),
    .l_lanes  (l_lanes),
    .l_bank   (l_bank),
    .l_rdata  (l_rdata),
    .l_noacc  (l_noacc),
    .r_ce0    (r_ce0),
    .r_ce1    (r_ce1),
    .r_rw     (r_rw),
    .r_oe     (r_oe),
    .r_lanes  (r_lanes),
    .r_bank   (r_bank),
    .r_rdata  (r_rdata),
    .r_noacc  (r_noacc)
);

// File: tb/bsdp_mem_tb_top.sv
`timescale 1ns/1ps
module bsdp_mem_tb_top;
    localparam int DATA_W    = 16;
    localparam int WORD_AW   = 8;
    localparam int NUM_BANKS = 4;
    localparam int LANES     = DATA_W / 8;
    localparam int BANK_AW   = 2;
    localparam int WORDS     = 1 << WORD_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NUM_BANKS-1:0] bank_sel;
    logic l_ce0, l_ce1, l_rw, l_oe, l_noacc;
    logic r_ce0, r_ce1, r_rw, r_oe, r_noacc;
    logic [LANES-1:0]   l_lanes, r_lanes;
    logic [BANK_AW-1:0] l_bank, r_bank;
    logic [WORD_AW-1:0] l_addr, r_addr;
    logic [DATA_W-1:0]  l_wdata, r_wdata, l_rdata, r_rdata;

    bsdp_mem #(.DATA_W(DATA_W), .WORD_AW(WORD_AW), .NUM_BANKS(NUM_BANKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .l_ce0(l_ce0), .l_ce1(l_ce1), .l_rw(l_rw), .l_oe(l_oe), .l_lanes(l_lanes),
        .l_bank(l_bank), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_noacc(l_noacc),
        .r_ce0(r_ce0), .r_ce1(r_ce1), .r_rw(r_rw), .r_oe(r_oe), .r_lanes(r_lanes),
        .r_bank(r_bank), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_noacc(r_noacc)
    );

    logic [DATA_W-1:0] ref_mem [NUM_BANKS][WORDS];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "";
    logic [DATA_W-1:0] exp_ld, exp_rd;
    logic  exp_ln, exp_rn;
    string tag_l, tag_r;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] ln);
        logic [DATA_W-1:0] m;
        for (int g = 0; g < LANES; g++) m[g*8 +: 8] = {8{ln[g]}};
        return m;
    endfunction

    // Bench model of one port: decides expected outputs and applies writes.
    task automatic model_port(input bit right, input logic ce0, ce1, rw, oe,
                              input logic [LANES-1:0] ln, input logic [BANK_AW-1:0] bk,
                              input logic [WORD_AW-1:0] ad, input logic [DATA_W-1:0] wd,
                              output logic [DATA_W-1:0] d, output logic na, output string tag);
        d = '0; na = 1'b0;
        if (!(ce0 && ce1)) tag = "R4";
        else if (bank_sel[bk] != right) begin na = 1'b1; tag = "R3"; end
        else if (!rw) begin
            ref_mem[bk][ad] = (ref_mem[bk][ad] & ~lane_mask(ln)) | (wd & lane_mask(ln));
            tag = "R6";
        end
        else if (!oe) tag = "R5";
        else begin
            d = ref_mem[bk][ad] & lane_mask(ln);
            tag = (ln == '1) ? "R5" : "R7";
        end
        if (phase != "") tag = phase;
    endtask

    task automatic check(input string tag, input string side, input logic [DATA_W-1:0] d,
                         input logic [DATA_W-1:0] ed, input logic na, input logic ena);
        n_chk++;
        if (d !== ed || na !== ena) begin
            n_fail++;
            $display("FAIL %s %s port: rdata=%h noacc=%b expected rdata=%h noacc=%b",
                     tag, side, d, na, ed, ena);
        end
    endtask

    task automatic step();
        model_port(1'b0, l_ce0, l_ce1, l_rw, l_oe, l_lanes, l_bank, l_addr, l_wdata, exp_ld, exp_ln, tag_l);
        model_port(1'b1, r_ce0, r_ce1, r_rw, r_oe, r_lanes, r_bank, r_addr, r_wdata, exp_rd, exp_rn, tag_r);
        @(negedge clk);
        check(tag_l, "left", l_rdata, exp_ld, l_noacc, exp_ln);
        check(tag_r, "right", r_rdata, exp_rd, r_noacc, exp_rn);
    endtask

    task automatic set_l(input logic ce, rw, oe, input logic [LANES-1:0] ln,
                         input int bk, input int ad, input logic [DATA_W-1:0] wd);
        l_ce0 = ce; l_ce1 = ce; l_rw = rw; l_oe = oe; l_lanes = ln;
        l_bank = BANK_AW'(bk); l_addr = WORD_AW'(ad); l_wdata = wd;
    endtask

    task automatic set_r(input logic ce, rw, oe, input logic [LANES-1:0] ln,
                         input int bk, input int ad, input logic [DATA_W-1:0] wd);
        r_ce0 = ce; r_ce1 = ce; r_rw = rw; r_oe = oe; r_lanes = ln;
        r_bank = BANK_AW'(bk); r_addr = WORD_AW'(ad); r_wdata = wd;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        bank_sel = '0;
        set_l(1'b1, 1'b1, 1'b1, '1, 0, 0, '0);
        set_r(1'b1, 1'b1, 1'b1, '1, 0, 0, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_l(1'b0, 1'b1, 1'b1, '1, 0, 0, '0);
        set_r(1'b0, 1'b1, 1'b1, '1, 0, 0, '0);
        // R1: outputs idle after reset
        check("R1", "left", l_rdata, '0, l_noacc, 1'b0);
        check("R1", "right", r_rdata, '0, r_noacc, 1'b0);

        // R2: left owns everything and fills all banks, then right owns and reads back
        phase = "R2";
        for (int b = 0; b < NUM_BANKS; b++)
            for (int a = 0; a < WORDS; a++) begin
                set_l(1'b1, 1'b0, 1'b0, '1, b, a, DATA_W'($urandom));
                step();
            end
        set_l(1'b0, 1'b1, 1'b1, '1, 0, 0, '0);
        bank_sel = '1;
        for (int b = 0; b < NUM_BANKS; b++)
            for (int a = 0; a < WORDS; a += 7) begin
                set_r(1'b1, 1'b1, 1'b1, '1, b, a, '0);
                step();
            end
        set_r(1'b0, 1'b1, 1'b1, '1, 0, 0, '0);

        // R9: same word address in every bank holds a different value
        phase = "R9";
        bank_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin set_l(1'b1, 1'b0, 1'b1, '1, b, 5, 16'hA000 + 16'(b)); step(); end
        for (int b = 0; b < NUM_BANKS; b++) begin set_l(1'b1, 1'b1, 1'b1, '1, b, 5, '0); step(); end

        // R6: single-lane writes keep the other byte
        phase = "R6";
        set_l(1'b1, 1'b0, 1'b1, 2'b11, 1, 3, 16'hFFFF); step();
        set_l(1'b1, 1'b0, 1'b1, 2'b01, 1, 3, 16'h3412); step();
        set_l(1'b1, 1'b1, 1'b1, 2'b11, 1, 3, '0); step();
        set_l(1'b1, 1'b0, 1'b1, 2'b10, 1, 3, 16'h56AB); step();
        set_l(1'b1, 1'b1, 1'b1, 2'b11, 1, 3, '0); step();

        // R3: left writes into a right-owned bank; right reads old content
        phase = "R3";
        bank_sel = 4'b0100;
        set_l(1'b1, 1'b0, 1'b1, '1, 2, 5, 16'hDEAD); step();
        set_l(1'b0, 1'b1, 1'b1, '1, 0, 0, '0);
        set_r(1'b1, 1'b1, 1'b1, '1, 2, 5, '0); step();

        // R8: both ports active in owned banks in the same cycle
        phase = "R8";
        bank_sel = 4'b1010;
        set_l(1'b1, 1'b0, 1'b1, '1, 0, 7, 16'h1111);
        set_r(1'b1, 1'b0, 1'b1, '1, 1, 7, 16'h2222); step();
        set_l(1'b1, 1'b1, 1'b1, '1, 0, 7, '0);
        set_r(1'b1, 1'b1, 1'b1, '1, 1, 7, '0); step();

        // R10: handover in the same cycle as the access
        phase = "R10";
        bank_sel = 4'b0000;
        set_r(1'b0, 1'b1, 1'b1, '1, 0, 0, '0);
        set_l(1'b1, 1'b0, 1'b1, '1, 2, 9, 16'h5A5A); step();
        bank_sel = 4'b0100;
        set_l(1'b1, 1'b1, 1'b1, '1, 2, 9, '0);
        set_r(1'b1, 1'b1, 1'b1, '1, 2, 9, '0); step();

        // Random mix: fresh selects every cycle, narrow address window
        phase = "";
        for (int i = 0; i < 4000; i++) begin
            bank_sel = NUM_BANKS'($urandom);
            l_ce0 = ($urandom % 8) != 0; l_ce1 = ($urandom % 8) != 0;
            r_ce0 = ($urandom % 8) != 0; r_ce1 = ($urandom % 8) != 0;
            l_rw = 1'($urandom); l_oe = ($urandom % 4) != 0;
            r_rw = 1'($urandom); r_oe = ($urandom % 4) != 0;
            l_lanes = LANES'($urandom); r_lanes = LANES'($urandom);
            l_bank = BANK_AW'($urandom); r_bank = BANK_AW'($urandom);
            l_addr = WORD_AW'($urandom % 8); r_addr = WORD_AW'($urandom % 8);
            l_wdata = DATA_W'($urandom); r_wdata = DATA_W'($urandom);
            step();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule